// File: doc/BRIEF.md
# Programmable Condition Decoder

This block turns a small set of match signals into one condition flag per condition slot. The match signals are the AND and OR outputs of four priority groups, one timer comparator output and one counter comparator output. Each slot holds a 32-bit decode word. For every source, the word has an include bit and a required-value bit. A condition is true when at least one source is included and every included source equals its required value. A final invert bit flips that result.

Decode words are loaded through a synchronous write port that takes one address and one data word. A sequencer or a trigger stage next to the block reads the registered flags. The number of slots is a parameter. The bit positions inside the decode word are fixed, because the software that builds the words depends on them.

Top module: `cond_decoder`

## Requirements
- R1: While reset is asserted, and after it is released, every decode word is zero and `cond_true` is all zero until a word is written.
- R2: When `wr_en` is high at a rising edge and `wr_addr` = k < NUM_COND, `wr_data` is stored in slot k at that edge. It affects `cond_true[k]` from the next rising edge on.
- R3: For priority group g (0..3), bit 4g+1 includes `grp_and[g]` and bit 4g is the value it must have. Word 0x3 makes slot k follow `grp_and[0]` being 1, and word 0x30 does the same for `grp_and[1]`.
- R4: For priority group g, bit 4g+3 includes `grp_or[g]` and bit 4g+2 is the value it must have.
- R5: Bit 17 includes `tmr_hit` and bit 16 is its required value. Word 0x30000 is true exactly when `tmr_hit` is 1.
- R6: Bit 21 includes `cnt_hit` and bit 20 is its required value.
- R7: When several sources are included, the condition is true only if all of them match their required values.
- R8: A word with no include bit set evaluates to false before inversion. Bit 24 inverts the result, so word 0x01000000 is always true.
- R9: A write with `wr_addr` >= NUM_COND changes no slot and no output.
- R10: Bits 31:25, 23:22 and 19:18 of a decode word have no effect on the result.
- R11: `cond_true` is registered. It reflects the source values sampled at a rising edge, right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Decode word write strobe |
| wr_addr | input | ADDR_W | Slot index for the write |
| wr_data | input | 32 | Decode word value |
| grp_and | input | 4 | AND outputs of priority groups 0..3 |
| grp_or | input | 4 | OR outputs of priority groups 0..3 |
| tmr_hit | input | 1 | Timer comparator output |
| cnt_hit | input | 1 | Counter comparator output |
| cond_true | output | NUM_COND | Registered condition flag per slot |

## Verification
A change on a source input shows up on `cond_true` right after the first rising edge that samples it. A new decode word shows up one edge after the edge that writes it. The bench drives inputs on falling edges and samples one full edge later, from a shadow copy of the words. The latency scenario also samples half a cycle early, to confirm that the old value is still held before the edge.

// File: rtl/cond_decoder_pkg.sv
package cond_decoder_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned N_GROUPS = 4;
  localparam int unsigned N_SRC    = 2 * N_GROUPS + 2;
  // source index layout inside the evaluator
  localparam int unsigned SRC_TMR  = 2 * N_GROUPS;
  localparam int unsigned SRC_CNT  = 2 * N_GROUPS + 1;
  // fixed decode-word bit positions
  localparam int unsigned B_TMR_POL = 16;
  localparam int unsigned B_TMR_ACT = 17;
  localparam int unsigned B_CNT_POL = 20;
  localparam int unsigned B_CNT_ACT = 21;
  localparam int unsigned B_INVERT  = 24;

  typedef logic [WORD_W-1:0] dword_t;
  typedef logic [N_SRC-1:0]  srcvec_t;
endpackage

// File: rtl/cdec_word_bank.sv
module cdec_word_bank
  import cond_decoder_pkg::*;
#(
  parameter int unsigned NUM_COND = 6,
  parameter int unsigned ADDR_W   = (NUM_COND > 1) ? $clog2(NUM_COND) : 1
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        wr_en,
  input  logic [ADDR_W-1:0]           wr_addr,
  input  dword_t                      wr_data,
  output logic [NUM_COND-1:0][WORD_W-1:0] words_o
);
  logic [NUM_COND-1:0][WORD_W-1:0] words_q;
  logic [NUM_COND-1:0][WORD_W-1:0] words_d;
  logic [NUM_COND-1:0]             slot_we;

  // per-slot write enables; addresses past the last slot match nothing
  for (genvar k = 0; k < NUM_COND; k++) begin : g_sel
    assign slot_we[k] = wr_en && (wr_addr == ADDR_W'(k));
  end

  always_comb begin
    words_d = words_q;
    for (int k = 0; k < NUM_COND; k++) begin
      if (slot_we[k]) words_d[k] = wr_data;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      words_q <= '0;
    end else if (wr_en) begin
      words_q <= words_d;
    end
  end

  assign words_o = words_q;
endmodule

// File: rtl/cdec_field_split.sv
module cdec_field_split
  import cond_decoder_pkg::*;
(
  input  dword_t  word_i,
  output srcvec_t act_o,
  output srcvec_t pol_o,
  output logic    inv_o
);
  // group g: even index = AND output, odd index = OR output
  for (genvar g = 0; g < N_GROUPS; g++) begin : g_grp
    assign pol_o[2*g]   = word_i[4*g];
    assign act_o[2*g]   = word_i[4*g+1];
    assign pol_o[2*g+1] = word_i[4*g+2];
    assign act_o[2*g+1] = word_i[4*g+3];
  end
  assign act_o[SRC_TMR] = word_i[B_TMR_ACT];
  assign pol_o[SRC_TMR] = word_i[B_TMR_POL];
  assign act_o[SRC_CNT] = word_i[B_CNT_ACT];
  assign pol_o[SRC_CNT] = word_i[B_CNT_POL];
  assign inv_o          = word_i[B_INVERT];
endmodule

// File: rtl/cdec_cond_eval.sv
module cdec_cond_eval
  import cond_decoder_pkg::*;
(
  input  srcvec_t src_i,
  input  srcvec_t act_i,
  input  srcvec_t pol_i,
  input  logic    inv_i,
  output logic    hit_o
);
  logic any_act;
  logic mismatch;
  always_comb begin
    any_act  = |act_i;
    mismatch = |(act_i & (src_i ^ pol_i));
    hit_o    = (any_act & ~mismatch) ^ inv_i;
  end
endmodule

// File: rtl/cond_decoder.sv
module cond_decoder
  import cond_decoder_pkg::*;
#(
  parameter int unsigned NUM_COND = 6,
  parameter int unsigned ADDR_W   = (NUM_COND > 1) ? $clog2(NUM_COND) : 1
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [31:0]         wr_data,
  input  logic [3:0]          grp_and,
  input  logic [3:0]          grp_or,
  input  logic                tmr_hit,
  input  logic                cnt_hit,
  output logic [NUM_COND-1:0] cond_true
);
  logic [NUM_COND-1:0][WORD_W-1:0] words_q;
  srcvec_t                         src_vec;
  logic [NUM_COND-1:0]             hit_d;
  logic [NUM_COND-1:0]             hit_q;

  cdec_word_bank #(.NUM_COND(NUM_COND), .ADDR_W(ADDR_W)) u_bank (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .wr_data (wr_data),
    .words_o (words_q)
  );

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_src
    assign src_vec[2*g]   = grp_and[g];
    assign src_vec[2*g+1] = grp_or[g];
  end
  assign src_vec[SRC_TMR] = tmr_hit;
  assign src_vec[SRC_CNT] = cnt_hit;

  for (genvar k = 0; k < NUM_COND; k++) begin : g_cond
    srcvec_t act;
    srcvec_t pol;
    logic    inv;
    cdec_field_split u_split (
      .word_i (words_q[k]),
      .act_o  (act),
      .pol_o  (pol),
      .inv_o  (inv)
    );
    cdec_cond_eval u_eval (
      .src_i (src_vec),
      .act_i (act),
      .pol_i (pol),
      .inv_i (inv),
      .hit_o (hit_d[k])
    );
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) hit_q <= '0;
    else        hit_q <= hit_d;
  end

  assign cond_true = hit_q;
endmodule

// File: rtl/cond_decoder_chk.sv
module cond_decoder_chk #(
  parameter int unsigned NUM_COND = 6,
  parameter int unsigned ADDR_W   = 3
) (
  input logic                     clk,
  input logic                     rst_n,
  input logic                     wr_en,
  input logic [ADDR_W-1:0]        wr_addr,
  input logic [31:0]              wr_data,
  input logic [3:0]               grp_and,
  input logic                     tmr_hit,
  input logic [NUM_COND-1:0]      cond_true,
  input logic [NUM_COND-1:0][31:0] words
);
  p_reset_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(rst_n) |-> (cond_true == '0 && words == '0));

  p_bad_addr_ignored_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ({1'b0, wr_addr} >= (ADDR_W+1)'(NUM_COND))) |=> $stable(words));

  for (genvar k = 0; k < NUM_COND; k++) begin : g_slot
    p_slot_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_addr == ADDR_W'(k)) |=> words[k] == $past(wr_data));

    p_empty_false_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (words[k] == 32'h0) |=> !cond_true[k]);

    p_invert_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (words[k] == 32'h0100_0000) |=> cond_true[k]);

    p_and_track_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (words[k] == 32'h3) |=> cond_true[k] == $past(grp_and[0]));

    p_timer_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (words[k] == 32'h0003_0000) |=> cond_true[k] == $past(tmr_hit));
  end
endmodule

bind cond_decoder cond_decoder_chk #(.NUM_COND(NUM_COND), .ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .wr_data   (wr_data),
  .grp_and   (grp_and),
  .tmr_hit   (tmr_hit),
  .cond_true (cond_true),
  .words     (words_q)
);

// File: tb/cond_decoder_test.sv
`timescale 1ns/1ps
module cond_decoder_test;
  localparam int NC = 6;
  localparam int AW = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [31:0]   wr_data = '0;
  logic [3:0]    grp_and = '0;
  logic [3:0]    grp_or = '0;
  logic          tmr_hit = 1'b0;
  logic          cnt_hit = 1'b0;
  logic [NC-1:0] cond_true;

  int checks = 0;
  int failures = 0;
  logic [31:0] shadow [NC];

  always #4 clk = ~clk;

  cond_decoder #(.NUM_COND(NC), .ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .grp_and(grp_and), .grp_or(grp_or),
    .tmr_hit(tmr_hit), .cnt_hit(cnt_hit), .cond_true(cond_true)
  );

  function automatic logic model(logic [31:0] w, logic [3:0] a, logic [3:0] o,
                                 logic t, logic c);
    logic any = 1'b0;
    logic ok  = 1'b1;
    for (int g = 0; g < 4; g++) begin
      if (w[4*g+1]) begin any = 1'b1; if (a[g] != w[4*g])   ok = 1'b0; end
      if (w[4*g+3]) begin any = 1'b1; if (o[g] != w[4*g+2]) ok = 1'b0; end
    end
    if (w[17]) begin any = 1'b1; if (t != w[16]) ok = 1'b0; end
    if (w[21]) begin any = 1'b1; if (c != w[20]) ok = 1'b0; end
    return (any && ok) ^ w[24];
  endfunction

  task automatic check_bit(string req, int k, logic act, logic exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s slot %0d actual=%b expected=%b", req, k, act, exp);
    end
  endtask

  task automatic check_all(string req);
    for (int k = 0; k < NC; k++)
      check_bit(req, k, cond_true[k],
                model(shadow[k], grp_and, grp_or, tmr_hit, cnt_hit));
  endtask

  task automatic settle();
    @(posedge clk); @(negedge clk);
  endtask

  task automatic write_slot(int a, logic [31:0] d);
    wr_en = 1'b1; wr_addr = AW'(a); wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
    if (a < NC) shadow[a] = d;
  endtask

  task automatic drive(logic [3:0] a, logic [3:0] o, logic t, logic c);
    grp_and = a; grp_or = o; tmr_hit = t; cnt_hit = c;
  endtask

  task automatic t_reset_r1();
    for (int k = 0; k < NC; k++) shadow[k] = '0;
    drive(4'hF, 4'hF, 1'b1, 1'b1);
    settle();
    check_all("R1");
  endtask

  task automatic t_and_r3();
    write_slot(0, 32'h3);
    write_slot(1, 32'h30);
    write_slot(2, 32'h300);
    write_slot(3, 32'h2000);
    for (int p = 0; p < 16; p += 5) begin
      drive(4'(p), 4'(~p), 1'b0, 1'b0);
      settle();
      check_all("R3");
    end
  endtask

  task automatic t_or_r4();
    write_slot(0, 32'hC);
    write_slot(1, 32'h80);
    write_slot(2, 32'hC00);
    write_slot(3, 32'hC000);
    for (int p = 0; p < 16; p += 3) begin
      drive(4'(~p), 4'(p), 1'b1, 1'b0);
      settle();
      check_all("R4");
    end
  endtask

  task automatic t_tmr_cnt_r5_r6();
    write_slot(0, 32'h0003_0000);
    write_slot(1, 32'h0002_0000);
    write_slot(2, 32'h0030_0000);
    write_slot(3, 32'h0020_0000);
    write_slot(4, 32'h0033_0000);
    write_slot(5, 32'h0103_0000);
    for (int p = 0; p < 4; p++) begin
      drive(4'h0, 4'h0, p[0], p[1]);
      settle();
      check_all("R5");
      check_all("R6");
    end
  endtask

  task automatic t_combine_r7();
    write_slot(0, 32'h33);
    write_slot(1, 32'h0002_000C);
    write_slot(2, 32'h0033_C0C3);
    write_slot(3, 32'h0010_0001);
    write_slot(4, 32'h0020_A82E);
    write_slot(5, 32'h0103_0003);
    for (int i = 0; i < 64; i++) begin
      drive(i[3:0], {i[1:0], i[5:4]}, i[2], i[5]);
      settle();
      check_all("R7");
    end
  endtask

  task automatic t_empty_invert_r8();
    write_slot(0, 32'h0);
    write_slot(1, 32'h0100_0000);
    write_slot(2, 32'h0100_0003);
    for (int p = 0; p < 2; p++) begin
      drive({3'b0, p[0]}, 4'h0, 1'b0, 1'b0);
      settle();
      check_all("R8");
    end
  endtask

  task automatic t_bad_addr_r9();
    for (int k = 0; k < NC; k++) write_slot(k, 32'h0);
    drive(4'h0, 4'h0, 1'b0, 1'b0);
    write_slot(6, 32'h0100_0000);
    write_slot(7, 32'h0100_0000);
    settle();
    check_all("R9");
  endtask

  task automatic t_unused_r10();
    write_slot(0, 32'hFECC_0003);
    write_slot(1, 32'hFECC_0000);
    for (int p = 0; p < 2; p++) begin
      drive({3'b0, p[0]}, 4'h0, 1'b0, 1'b0);
      settle();
      check_all("R10");
    end
  endtask

  task automatic t_latency_r2_r11();
    write_slot(0, 32'h3);
    drive(4'h0, 4'h0, 1'b0, 1'b0);
    settle();
    drive(4'h1, 4'h0, 1'b0, 1'b0);
    #1;
    check_bit("R11", 0, cond_true[0], 1'b0);
    settle();
    check_bit("R11", 0, cond_true[0], 1'b1);
    // a new word takes one further edge to reach the output
    wr_en = 1'b1; wr_addr = '0; wr_data = 32'h0100_0003;
    @(negedge clk);
    wr_en = 1'b0; shadow[0] = 32'h0100_0003;
    check_bit("R2", 0, cond_true[0], 1'b1);
    settle();
    check_bit("R2", 0, cond_true[0], 1'b0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset_r1();
    rst_n = 1'b1;
    settle();
    check_all("R1");
    t_and_r3();
    t_or_r4();
    t_tmr_cnt_r5_r6();
    t_combine_r7();
    t_empty_invert_r8();
    t_bad_addr_r9();
    t_unused_r10();
    t_latency_r2_r11();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    failures++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule